// File: doc/BRIEF.md
# Handshaked Sample Scaling Filter

This block takes one 8-bit sample per return-to-zero request/acknowledge exchange. When the requester raises `start_i`, the block captures the sample and fills two registered results. `r_o` receives three times the sample. `res_o` receives four times the sample, unless one of the two top bits of the sample overrides it. The block then raises `done_o` and keeps it high until the requester drops `start_i`. It then lowers `done_o` and waits for the next request.

The design is fully synchronous. `start_i` passes through a two-flop synchronizer, so the requester may run from an unrelated timing domain. A small three-state sequencer paces the exchange. A combinational scaler feeds the result registers, and those registers load only when a request is accepted. Between requests both outputs hold their last values.

Top module: `hsf_top`

## Requirements
- R1: While no request is in progress and `start_i` stays low, `done_o` stays 0 and `r_o`/`res_o` do not change, whatever `sample_i` does.
- R2: On an accepted request, `r_o` becomes the sample multiplied by 3, as a 10-bit unsigned value.
- R3: When sample bit 7 and bit 6 are both 0, `res_o` becomes the sample multiplied by 4 (10-bit unsigned).
- R4: When sample bit 7 is 1, `res_o` becomes 0 whatever bit 6 holds.
- R5: When sample bit 7 is 0 and bit 6 is 1, `res_o` becomes 1.
- R6: `done_o` rises on the fourth rising clock edge after `start_i` is first seen high (two synchronizer edges, one load edge, one acknowledge edge), by which point both results already hold their new values. It stays high for as long as `start_i` stays high.
- R7: `done_o` falls on the third rising clock edge after `start_i` falls. After that, a new rise of `start_i` starts a new exchange.
- R8: The results are taken from the sample present when the request is accepted. Changes to `sample_i` after that point leave `r_o` and `res_o` unchanged until the next accepted request.
- R9: A synchronous active-high `rst` clears `done_o`, `r_o` and `res_o` and returns the block to waiting for a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 8 | Input sample; bit 7 and bit 6 also act as override flags |
| start_i | input | 1 | Request line, may be asynchronous to `clk` |
| done_o | output | 1 | Acknowledge line |
| r_o | output | 10 | Registered sample times 3 |
| res_o | output | 10 | Registered sample times 4, or the flag override value |

## Verification
A sequencer stuck in the acknowledge state shows up within three edges of `start_i` falling, because `done_o` stays high. A sequencer that skips the load step shows up at the first `done_o` rise, because the results are stale. A wrong priority between the two flag bits is visible only for samples with bit 7 set. The vectors therefore include 0xC0 and 0xFF next to samples that carry a single flag. A result register that loads outside an accepted request is caught one edge after `sample_i` changes while `done_o` is high or while the block is idle.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LOAD = 2'd1,
        ST_ACK  = 2'd2
    } hsf_state_e;

endpackage

// File: rtl/hsf_sync.sv
module hsf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/hsf_ctrl.sv
module hsf_ctrl
    import hsf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_s,
    output logic load_o,
    output logic done_o
);
    typedef struct packed {
        hsf_state_e st;
        logic       done;
    } ctrl_regs_t;

    ctrl_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        load_o = 1'b0;
        case (cur_q.st)
            ST_WAIT: begin
                if (start_s) begin
                    load_o   = 1'b1;
                    nxt_d.st = ST_LOAD;
                end
            end
            ST_LOAD: begin
                nxt_d.st   = ST_ACK;
                nxt_d.done = 1'b1;
            end
            ST_ACK: begin
                if (!start_s) begin
                    nxt_d.st   = ST_WAIT;
                    nxt_d.done = 1'b0;
                end
            end
            default: begin
                nxt_d.st   = ST_WAIT;
                nxt_d.done = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st   <= ST_WAIT;
            cur_q.done <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done_o = cur_q.done;

    // R6: acknowledge persists while the request stays up
    p_ack_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_ACK && start_s) |=> done_o);

    // R7: acknowledge drops once the request has gone
    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_s) |=> !done_o);

    // R8: no new capture while an exchange is acknowledged
    p_no_load_in_ack_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !load_o);

    // R1: without a request the sequencer stays idle
    p_idle_waits_r1: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_WAIT && !start_s) |=> (cur_q.st == ST_WAIT && !done_o));
endmodule

// File: rtl/hsf_calc.sv
module hsf_calc #(
    parameter int DATA_W = 8,
    parameter int OUT_W  = DATA_W + 2
) (
    input  logic [DATA_W-1:0] sample,
    output logic [OUT_W-1:0]  r_val,
    output logic [OUT_W-1:0]  res_val
);
    localparam int HI_FLAG = DATA_W - 1;
    localparam int LO_FLAG = DATA_W - 2;

    logic [OUT_W-1:0] wide;

    always_comb begin
        wide  = OUT_W'(sample);
        r_val = (wide << 1) + wide;
        if (sample[HI_FLAG])      res_val = '0;
        else if (sample[LO_FLAG]) res_val = OUT_W'(1);
        else                      res_val = wide << 2;
    end
endmodule

// File: rtl/hsf_top.sv
module hsf_top #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int OUT_W      = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              start_i,
    output logic              done_o,
    output logic [OUT_W-1:0]  r_o,
    output logic [OUT_W-1:0]  res_o
);
    typedef struct packed {
        logic [OUT_W-1:0] r;
        logic [OUT_W-1:0] res;
    } dp_regs_t;

    logic             start_s;
    logic             load;
    logic [OUT_W-1:0] r_val, res_val;
    dp_regs_t         dp_q, dp_d;

    hsf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (start_i),
        .dout(start_s)
    );

    hsf_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start_s(start_s),
        .load_o (load),
        .done_o (done_o)
    );

    hsf_calc #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_calc (
        .sample (sample_i),
        .r_val  (r_val),
        .res_val(res_val)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.r   = r_val;
            dp_d.res = res_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign r_o   = dp_q.r;
    assign res_o = dp_q.res;

    // R2: triple of the captured sample
    p_r_triple_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> r_o == OUT_W'($past(sample_i)) * OUT_W'(3));

    // R4: top flag forces zero
    p_res_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (load && sample_i[DATA_W-1]) |=> res_o == '0);

    // R5: second flag forces one
    p_res_one_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !sample_i[DATA_W-1] && sample_i[DATA_W-2]) |=> res_o == OUT_W'(1));

    // R8: results hold between captures
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(r_o) && $stable(res_o)));

    // R9: reset clears acknowledge and results
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!done_o && r_o == '0 && res_o == '0));
endmodule

// File: tb/tb_hsf_top.sv
module tb_hsf_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sample = 8'h00;
    logic       start = 1'b0;
    logic       done;
    logic [9:0] r, res;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hsf_top dut (
        .clk(clk), .rst(rst), .sample_i(sample), .start_i(start),
        .done_o(done), .r_o(r), .res_o(res)
    );

    // sample, expected r, expected res
    localparam logic [27:0] VEC [0:8] = '{
        {8'h00, 10'd0,   10'd0},
        {8'h05, 10'd15,  10'd20},
        {8'h3F, 10'd189, 10'd252},
        {8'h2A, 10'd126, 10'd168},
        {8'h40, 10'd192, 10'd1},
        {8'h7F, 10'd381, 10'd1},
        {8'h80, 10'd384, 10'd0},
        {8'hC0, 10'd576, 10'd0},
        {8'hFF, 10'd765, 10'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic exchange(input logic [7:0] s, input int er, input int eres);
        int n = 0;
        logic [9:0] r_hold, res_hold;
        @(negedge clk);
        sample = s;
        start  = 1'b1;
        while (n < 20) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (done) break;
        end
        check("R6 done rise latency", n, 4);
        check("R2 r value", int'(r), er);
        if (s[7])      check("R4 res forced zero", int'(res), eres);
        else if (s[6]) check("R5 res forced one", int'(res), eres);
        else           check("R3 res times four", int'(res), eres);
        r_hold = r; res_hold = res;
        sample = ~s;
        repeat (3) @(negedge clk);
        check("R6 done held while start high", int'(done), 1);
        check("R8 r ignores late sample", int'(r), int'(r_hold));
        check("R8 res ignores late sample", int'(res), int'(res_hold));
        start = 1'b0;
        n = 0;
        while (n < 20) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!done) break;
        end
        check("R7 done fall latency", n, 3);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 done after reset", int'(done), 0);
        check("R9 r after reset", int'(r), 0);
        check("R9 res after reset", int'(res), 0);
        rst = 1'b0;

        for (int i = 0; i < 9; i++) begin
            exchange(VEC[i][27:20], int'(VEC[i][19:10]), int'(VEC[i][9:0]));
        end

        // R1: idle with start low, sample wiggling
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            sample = 8'(k * 37 + 3);
        end
        repeat (2) @(negedge clk);
        check("R1 done idle", int'(done), 0);
        check("R1 r idle", int'(r), 765);
        check("R1 res idle", int'(res), 0);

        // R7: back-to-back exchange accepted after completion
        exchange(8'h01, 3, 4);

        // R9: reset in the middle of an acknowledge
        @(negedge clk);
        sample = 8'h10; start = 1'b1;
        repeat (5) @(negedge clk);
        check("R6 done before mid reset", int'(done), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 done cleared mid exchange", int'(done), 0);
        check("R9 r cleared mid exchange", int'(r), 0);
        check("R9 res cleared mid exchange", int'(res), 0);
        start = 1'b0;
        repeat (4) @(negedge clk);
        exchange(8'h10, 48, 64);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule